// File: doc/BRIEF.md
# Two-Way Posted-Write Bridge with Ordered Read Flush

This block joins a source bus, where requesters issue reads and writes, to a target bus, which also sends writes back toward the source side. Writes going either way are posted. The bridge takes each write in the cycle it is offered, as long as that direction's queue has room, and forwards it later in arrival order. Memory-space writes and I/O-space writes are queued and ordered in exactly the same way. A one-bit space flag travels with each write and is passed through unchanged.

A read from the source side must not return stale data. The bridge handles it in four steps, always in this order:

1. It drains every write queued toward the target bus.
2. It presents the read on the target bus.
3. Once the target accepts the read, it drains the writes that were queued toward the source bus at that moment.
4. It hands the read data back to the source requester.

Only one read is in flight at a time. Ordering is enforced only through bus transactions; no side-band signal takes part in it.

Every data path is a valid/ready stream. A transfer happens on a clock edge where valid and ready are both high. A source that raises valid may not assume a transfer until it sees ready. The bridge holds its own valid outputs, and the payload that goes with them, stable until each transfer completes. The target's read-data return is a plain valid strobe, with no ready, and the bridge samples it only while it waits for read data. Reset is synchronous and active high.

Top module: `pw_bridge`

## Requirements
- R1: A source write (`src_req_write`=1) is accepted in the same cycle when the bridge is idle and the target-bound queue holds fewer than DEPTH entries. From the next cycle on it appears on `dst_cmd_*` with `dst_cmd_write`=1, and target-bound writes leave in the order they arrived.
- R2: A target write on `dst_wr_*` is accepted whenever the source-bound queue holds fewer than DEPTH entries. From the next cycle on it appears on `src_wr_*`, and source-bound writes leave in the order they arrived.
- R3: Each queue holds DEPTH (default 8) entries. A queue holding DEPTH entries drives its ingress ready low, even in a cycle where it is also emptying an entry.
- R4: After a read (`src_req_write`=0) is accepted, no read is presented on `dst_cmd_*` until every target-bound write queued ahead of it has been transferred. The read appears in the cycle after the queue is seen empty.
- R5: The read is presented with `dst_cmd_write`=0, the read's address and space flag, and `dst_cmd_data`=0. It is held until `dst_cmd_ready` is high.
- R6: When the target accepts the read, the bridge latches a count equal to the source-bound queue occupancy minus any entry leaving in that same cycle. `src_rsp_valid` rises only after that many source-bound entries have been transferred, and no earlier than the second cycle after the read data has been captured. Writes that enter later are not waited for.
- R7: Read data is captured from the first `dst_rdata_valid` strobe after the read is accepted, and strobes at any other time are ignored. `src_rsp_valid` and `src_rsp_data` stay steady until `src_rsp_ready` is high.
- R8: From the cycle a read is accepted until its response is taken, `src_req_ready` is low for reads and writes alike.
- R9: The space flag (`*_io`, 1 = I/O space, 0 = memory space) is carried unchanged, and the order of transactions does not depend on it.
- R10: While `rst` is high at a clock edge, both queues are emptied and the read sequencer returns to idle. After that edge every outbound valid is low and both write-ingress readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_valid | input | 1 | Source request valid |
| src_req_ready | output | 1 | Source request accepted |
| src_req_write | input | 1 | 1 = write, 0 = read |
| src_req_io | input | 1 | Space flag, 1 = I/O |
| src_req_addr | input | ADDR_W | Request address |
| src_req_data | input | DATA_W | Write data (unused for reads) |
| src_rsp_valid | output | 1 | Read data ready for the source |
| src_rsp_ready | input | 1 | Source takes read data |
| src_rsp_data | output | DATA_W | Read data |
| dst_cmd_valid | output | 1 | Transaction to target bus valid |
| dst_cmd_ready | input | 1 | Target accepts transaction |
| dst_cmd_write | output | 1 | 1 = forwarded write, 0 = read |
| dst_cmd_io | output | 1 | Space flag |
| dst_cmd_addr | output | ADDR_W | Address |
| dst_cmd_data | output | DATA_W | Write data, 0 for reads |
| dst_rdata_valid | input | 1 | Read data strobe from target |
| dst_rdata | input | DATA_W | Read data from target |
| dst_wr_valid | input | 1 | Write from target bus valid |
| dst_wr_ready | output | 1 | Write from target accepted |
| dst_wr_io | input | 1 | Space flag |
| dst_wr_addr | input | ADDR_W | Address |
| dst_wr_data | input | DATA_W | Write data |
| src_wr_valid | output | 1 | Forwarded write to source bus valid |
| src_wr_ready | input | 1 | Source bus accepts the write |
| src_wr_io | output | 1 | Space flag |
| src_wr_addr | output | ADDR_W | Address |
| src_wr_data | output | DATA_W | Write data |

## Verification
Readies are combinational and due in the same cycle as the request. A queued write shows at its egress in the cycle after it is accepted. The read command shows in the cycle after the target-bound queue is seen empty, and the response shows in the cycle after the latched count reaches zero with the data already captured. A behavioural model built from queues and integers predicts every output for every cycle. The bench drives inputs on the falling edge, compares shortly after, and advances the model at the rising edge from the same sampled handshakes, so each result is checked in exactly the cycle it is due. Stimulus phases starve each egress in turn, so that queues fill and latched drain counts are nonzero, and a reset is applied in the middle of the run.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_FLUSH_DN,
    RS_ISSUE,
    RS_WAIT,
    RS_RESP
  } rd_state_e;
endpackage

// File: rtl/pw_fifo.sv
module pw_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             push, pop;

  assign in_ready  = (level != CW'(DEPTH));
  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= in_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      level <= level + CW'(push) - CW'(pop);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  // R1
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pw_rd_seq.sv
module pw_rd_seq
  import pw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_accept,
  input  logic [ADDR_W-1:0] rd_addr_in,
  input  logic              rd_io_in,
  input  logic [CW-1:0]     dn_level,
  input  logic [CW-1:0]     up_level,
  input  logic              up_pop,
  output logic              idle,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [ADDR_W-1:0] issue_addr,
  output logic              issue_io,
  input  logic              rdata_valid,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  rd_state_e         state;
  logic [CW-1:0]     drain_q;
  logic              have_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic              io_q;

  assign idle        = (state == RS_IDLE);
  assign issue_valid = (state == RS_ISSUE);
  assign issue_addr  = addr_q;
  assign issue_io    = io_q;
  assign rsp_valid   = (state == RS_RESP);
  assign rsp_data    = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RS_IDLE;
      drain_q <= '0;
      have_q  <= 1'b0;
      data_q  <= '0;
      addr_q  <= '0;
      io_q    <= 1'b0;
    end else begin
      case (state)
        RS_IDLE: if (rd_accept) begin
          addr_q <= rd_addr_in;
          io_q   <= rd_io_in;
          state  <= RS_FLUSH_DN;
        end
        RS_FLUSH_DN: if (dn_level == '0) state <= RS_ISSUE;
        RS_ISSUE: if (issue_ready) begin
          drain_q <= up_level - CW'(up_pop);
          have_q  <= 1'b0;
          state   <= RS_WAIT;
        end
        RS_WAIT: begin
          if (have_q && drain_q == '0) state <= RS_RESP;
          if (rdata_valid && !have_q) begin
            have_q <= 1'b1;
            data_q <= rdata_in;
          end
          if (up_pop && drain_q != '0) drain_q <= drain_q - 1'b1;
        end
        RS_RESP: if (rsp_ready) state <= RS_IDLE;
        default: state <= RS_IDLE;
      endcase
    end
  end

  // R4
  issue_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (dn_level == '0));

  // R5
  issue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_addr)));

  // R6
  rsp_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (drain_q == '0 && dn_level == '0));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/pw_bridge.sv
module pw_bridge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int EW = 1 + ADDR_W + DATA_W,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_req_valid,
  output logic              src_req_ready,
  input  logic              src_req_write,
  input  logic              src_req_io,
  input  logic [ADDR_W-1:0] src_req_addr,
  input  logic [DATA_W-1:0] src_req_data,
  output logic              src_rsp_valid,
  input  logic              src_rsp_ready,
  output logic [DATA_W-1:0] src_rsp_data,
  output logic              dst_cmd_valid,
  input  logic              dst_cmd_ready,
  output logic              dst_cmd_write,
  output logic              dst_cmd_io,
  output logic [ADDR_W-1:0] dst_cmd_addr,
  output logic [DATA_W-1:0] dst_cmd_data,
  input  logic              dst_rdata_valid,
  input  logic [DATA_W-1:0] dst_rdata,
  input  logic              dst_wr_valid,
  output logic              dst_wr_ready,
  input  logic              dst_wr_io,
  input  logic [ADDR_W-1:0] dst_wr_addr,
  input  logic [DATA_W-1:0] dst_wr_data,
  output logic              src_wr_valid,
  input  logic              src_wr_ready,
  output logic              src_wr_io,
  output logic [ADDR_W-1:0] src_wr_addr,
  output logic [DATA_W-1:0] src_wr_data
);
  logic          seq_idle, issue_valid, issue_io;
  logic [ADDR_W-1:0] issue_addr;
  logic          dn_in_valid, dn_in_ready, dn_out_valid, dn_out_ready;
  logic [EW-1:0] dn_in, dn_head, up_in, up_head;
  logic [CW-1:0] dn_level, up_level;
  logic          rd_accept, up_pop;

  assign src_req_ready = seq_idle && (src_req_write ? dn_in_ready : 1'b1);
  assign dn_in_valid   = src_req_valid && src_req_write && seq_idle;
  assign rd_accept     = src_req_valid && src_req_ready && !src_req_write;
  assign dn_in         = {src_req_io, src_req_addr, src_req_data};
  assign dn_out_ready  = dst_cmd_ready && !issue_valid;

  pw_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_dn_q (
    .clk(clk), .rst(rst),
    .in_valid(dn_in_valid), .in_ready(dn_in_ready), .in_data(dn_in),
    .out_valid(dn_out_valid), .out_ready(dn_out_ready), .out_data(dn_head),
    .level(dn_level)
  );

  assign up_in  = {dst_wr_io, dst_wr_addr, dst_wr_data};
  assign up_pop = src_wr_valid && src_wr_ready;

  pw_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_up_q (
    .clk(clk), .rst(rst),
    .in_valid(dst_wr_valid), .in_ready(dst_wr_ready), .in_data(up_in),
    .out_valid(src_wr_valid), .out_ready(src_wr_ready), .out_data(up_head),
    .level(up_level)
  );

  assign src_wr_io   = up_head[EW-1];
  assign src_wr_addr = up_head[DATA_W +: ADDR_W];
  assign src_wr_data = up_head[DATA_W-1:0];

  pw_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst),
    .rd_accept(rd_accept), .rd_addr_in(src_req_addr), .rd_io_in(src_req_io),
    .dn_level(dn_level), .up_level(up_level), .up_pop(up_pop),
    .idle(seq_idle),
    .issue_valid(issue_valid), .issue_ready(dst_cmd_ready),
    .issue_addr(issue_addr), .issue_io(issue_io),
    .rdata_valid(dst_rdata_valid), .rdata_in(dst_rdata),
    .rsp_valid(src_rsp_valid), .rsp_ready(src_rsp_ready), .rsp_data(src_rsp_data)
  );

  // Target-side command mux: the read slot only exists once the queue is empty.
  always_comb begin
    if (issue_valid) begin
      dst_cmd_valid = 1'b1;
      dst_cmd_write = 1'b0;
      dst_cmd_io    = issue_io;
      dst_cmd_addr  = issue_addr;
      dst_cmd_data  = '0;
    end else begin
      dst_cmd_valid = dn_out_valid;
      dst_cmd_write = 1'b1;
      dst_cmd_io    = dn_head[EW-1];
      dst_cmd_addr  = dn_head[DATA_W +: ADDR_W];
      dst_cmd_data  = dn_head[DATA_W-1:0];
    end
  end

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    src_rsp_valid |-> !src_req_ready);
endmodule

// File: tb/pw_bridge_tb.sv
module pw_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int EW = 1 + AW + DW;
  localparam int CYCLES = 6000;

  logic clk = 1'b0, rst = 1'b1;
  logic src_req_valid = 0, src_req_ready, src_req_write = 0, src_req_io = 0;
  logic [AW-1:0] src_req_addr = '0;
  logic [DW-1:0] src_req_data = '0;
  logic src_rsp_valid, src_rsp_ready = 0;
  logic [DW-1:0] src_rsp_data;
  logic dst_cmd_valid, dst_cmd_ready = 0, dst_cmd_write, dst_cmd_io;
  logic [AW-1:0] dst_cmd_addr;
  logic [DW-1:0] dst_cmd_data;
  logic dst_rdata_valid = 0;
  logic [DW-1:0] dst_rdata = '0;
  logic dst_wr_valid = 0, dst_wr_ready, dst_wr_io = 0;
  logic [AW-1:0] dst_wr_addr = '0;
  logic [DW-1:0] dst_wr_data = '0;
  logic src_wr_valid, src_wr_ready = 0, src_wr_io;
  logic [AW-1:0] src_wr_addr;
  logic [DW-1:0] src_wr_data;

  pw_bridge #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // Behavioural reference: two queues plus a phase counter for the read.
  logic [EW-1:0] qdn[$], qup[$];
  int  ph = 0;           // 0 idle, 1 flush, 2 issue, 3 wait, 4 respond
  int  drain = 0;
  bit  have = 0;
  logic [AW-1:0] m_addr = '0;
  logic m_io = 0;
  logic [DW-1:0] m_rdata = '0;

  initial begin
    bit e_areq_rdy, e_dwr_rdy, e_cmd_v, e_cmd_w, e_swr_v, e_rsp_v;
    logic [EW-1:0] e_cmd_ent;
    int mode, szd, szu;
    bit dn_pop, dn_push, up_pop, up_push;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(negedge clk);
      mode = (cyc / 250) % 4;
      rst  = (cyc < 3) || (cyc >= 3000 && cyc < 3002);
      src_req_valid   = ($urandom_range(0, 99) < 60);
      src_req_write   = ($urandom_range(0, 3) != 0);
      src_req_io      = $urandom_range(0, 1);
      src_req_addr    = AW'($urandom);
      src_req_data    = $urandom;
      dst_wr_valid    = ($urandom_range(0, 99) < ((mode == 2) ? 70 : 40));
      dst_wr_io       = $urandom_range(0, 1);
      dst_wr_addr     = AW'($urandom);
      dst_wr_data     = $urandom;
      dst_cmd_ready   = ($urandom_range(0, 99) < ((mode == 1) ? 10 : 75));
      src_wr_ready    = ($urandom_range(0, 99) < ((mode == 2) ? 12 : 70));
      dst_rdata_valid = ($urandom_range(0, 99) < 30);
      dst_rdata       = $urandom;
      src_rsp_ready   = ($urandom_range(0, 99) < 60);
      #1;
      szd = qdn.size();
      szu = qup.size();
      e_areq_rdy = (ph == 0) && (src_req_write ? (szd < DEPTH) : 1'b1);
      e_dwr_rdy  = (szu < DEPTH);
      e_cmd_v    = (ph == 2) || (szd > 0);
      e_cmd_w    = (ph != 2);
      e_cmd_ent  = (ph == 2) ? {m_io, m_addr, DW'(0)} : ((szd > 0) ? qdn[0] : '0);
      e_swr_v    = (szu > 0);
      e_rsp_v    = (ph == 4);
      if (!rst) begin
        if (cyc == 3 || cyc == 3002) begin
          // R10: after reset every outbound valid is low and write ingress is open
          check({dst_cmd_valid, src_wr_valid, src_rsp_valid, dst_wr_ready} == 4'b0001,
                "R10 post-reset state", {dst_cmd_valid, src_wr_valid, src_rsp_valid, dst_wr_ready},
                4'b0001);
        end
        check(src_req_ready == e_areq_rdy, "R8 R3 src_req_ready", src_req_ready, e_areq_rdy);
        check(dst_wr_ready == e_dwr_rdy, "R3 dst_wr_ready", dst_wr_ready, e_dwr_rdy);
        check(dst_cmd_valid == e_cmd_v, "R4 dst_cmd_valid", dst_cmd_valid, e_cmd_v);
        if (e_cmd_v) begin
          // R1 forwarded writes, R5 read command, R9 space flag
          check({dst_cmd_write, dst_cmd_io, dst_cmd_addr, dst_cmd_data} == {e_cmd_w, e_cmd_ent},
                "R1 R5 R9 dst_cmd payload",
                {dst_cmd_write, dst_cmd_io, dst_cmd_addr[14:0], dst_cmd_data},
                {e_cmd_w, e_cmd_ent[EW-1:0]});
        end
        check(src_wr_valid == e_swr_v, "R2 src_wr_valid", src_wr_valid, e_swr_v);
        if (e_swr_v)
          check({src_wr_io, src_wr_addr, src_wr_data} == qup[0], "R2 R9 src_wr payload",
                {src_wr_io, src_wr_addr, src_wr_data}, qup[0]);
        check(src_rsp_valid == e_rsp_v, "R6 src_rsp_valid", src_rsp_valid, e_rsp_v);
        if (e_rsp_v)
          check(src_rsp_data == m_rdata, "R7 src_rsp_data", src_rsp_data, m_rdata);
      end
      @(posedge clk);
      if (rst) begin
        qdn.delete();
        qup.delete();
        ph = 0; drain = 0; have = 0;
      end else begin
        dn_pop  = e_cmd_v && dst_cmd_ready && (ph != 2);
        dn_push = src_req_valid && e_areq_rdy && src_req_write;
        up_pop  = e_swr_v && src_wr_ready;
        up_push = dst_wr_valid && e_dwr_rdy;
        case (ph)
          0: if (src_req_valid && e_areq_rdy && !src_req_write) begin
               m_addr = src_req_addr; m_io = src_req_io; ph = 1;
             end
          1: if (szd == 0) ph = 2;
          2: if (dst_cmd_ready) begin
               drain = szu - int'(up_pop); have = 0; ph = 3;
             end
          3: begin
               if (have && drain == 0) ph = 4;
               if (dst_rdata_valid && !have) begin have = 1; m_rdata = dst_rdata; end
               if (up_pop && drain > 0) drain--;
             end
          4: if (src_rsp_ready) ph = 0;
          default: ph = 0;
        endcase
        if (dn_pop) void'(qdn.pop_front());
        if (dn_push) qdn.push_back({src_req_io, src_req_addr, src_req_data});
        if (up_pop) void'(qup.pop_front());
        if (up_push) qup.push_back({dst_wr_io, dst_wr_addr, dst_wr_data});
      end
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule